// File: doc/BRIEF.md
# Periodic Bitstream Replayer

This block holds a fixed-length single-bit pattern, such as a stretch recorded from a delta-sigma modulator. It plays the pattern back in a loop as a one-bit stream at the clock rate. That stream drives an external analog reconstruction filter. The frequency and amplitude of the recovered waveform depend only on how many ones the stored pattern holds and where they sit. DC levels, single tones, multi-tone signals and sawtooth shapes all use the same hardware; only the loaded pattern changes.

Storage is a ring of flip-flops with a 2-to-1 select at each stage. When `loop_sel` is low, the ring acts as a serial shift register that takes bits from `ser_in`. When `loop_sel` is high, the last stage feeds the first and the pattern circulates. A phase counter runs beside the ring and raises `wrap_strobe` on the cycle in which the pattern starts over. The pattern length is set by the parameter `PAT_LEN`.

Top module: `bitstream_replayer`

## Requirements
- R1: Synchronous active-high reset clears every stored bit and the phase counter. Entering loop mode after reset with no load produces an all-zero stream, and `wrap_strobe` fires in the first loop cycle.
- R2: With `loop_sel` = 0 (load mode), each clock shifts `ser_in` into the first stage and moves every older bit one stage toward the output. In this mode `bit_out` and `wrap_strobe` are both held at 0.
- R3: With `loop_sel` = 1 (loop mode), `bit_out` shows the last stage, and the last stage is fed back into the first stage on every clock. Suppose exactly `PAT_LEN` bits were loaded. Then the first loop cycle outputs the first bit loaded, and the following cycles output the rest in the order they were loaded.
- R4: While `loop_sel` stays high, the output stream repeats with a period of exactly `PAT_LEN` cycles, for as long as loop mode lasts.
- R5: `wrap_strobe` is high for one cycle in the first loop cycle and again every `PAT_LEN` cycles after that, and is low in all other cycles.
- R6: If more than `PAT_LEN` bits are loaded, only the most recent `PAT_LEN` are kept. Replay starts with the oldest bit that was kept.
- R7: The number of ones in each replay period equals the number of ones in the loaded pattern, for any pattern (all ones, all zeros, alternating, irregular).
- R8: Leaving loop mode in the middle of a period and then loading a full new pattern replaces all stored bits. On the next entry to loop mode the phase starts again from zero, so replay begins with the new pattern's first bit together with `wrap_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one output bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial pattern bit, taken in load mode |
| loop_sel | input | 1 | 0 = load mode, 1 = loop (replay) mode |
| bit_out | output | 1 | Replayed bit; 0 in load mode |
| wrap_strobe | output | 1 | One-cycle marker at the start of each period |

## Verification
The assertions assume that `loop_sel` and `ser_in` are synchronous to `clk` and stay stable around each rising edge. `bit_out` and `wrap_strobe` follow `loop_sel` in the same cycle, so a glitching select would break the relation checked at the edge. The stimulus changes inputs only on falling edges and samples outputs a short time after that. The period-spacing and ones-density properties only compare periods within one unbroken stretch of loop mode. For that reason the stimulus always leaves loop mode before it loads a new pattern.

// File: rtl/replay_pkg.sv
package replay_pkg;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_LOOP = 1'b1
    } replay_mode_e;

    typedef struct packed {
        logic bit_val;
        logic wrap;
    } replay_out_t;

    function automatic int unsigned phase_width(input int unsigned len);
        return (len < 2) ? 1 : $clog2(len);
    endfunction

endpackage

// File: rtl/replay_stage.sv
module replay_stage
    import replay_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  replay_mode_e mode,
    input  logic         load_d,
    input  logic         loop_d,
    output logic         q
);
    logic d_sel;

    // 2-to-1 select in front of the flop
    always_comb begin
        d_sel = (mode == MODE_LOOP) ? loop_d : load_d;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d_sel;
    end
endmodule

// File: rtl/replay_chain.sv
module replay_chain
    import replay_pkg::*;
#(
    parameter int unsigned LEN = 392
) (
    input  logic         clk,
    input  logic         rst,
    input  replay_mode_e mode,
    input  logic         ser_in,
    output logic         tail
);
    localparam int unsigned LAST = LEN - 1;

    logic [LEN-1:0] q;

    generate
        for (genvar i = 0; i < LEN; i++) begin : g_stage
            if (i == 0) begin : g_head
                // head stage: external data or the fed-back tail
                replay_stage u_stage (
                    .clk    (clk),
                    .rst    (rst),
                    .mode   (mode),
                    .load_d (ser_in),
                    .loop_d (q[LAST]),
                    .q      (q[i])
                );
            end else begin : g_body
                replay_stage u_stage (
                    .clk    (clk),
                    .rst    (rst),
                    .mode   (mode),
                    .load_d (q[i-1]),
                    .loop_d (q[i-1]),
                    .q      (q[i])
                );
            end
        end
    endgenerate

    assign tail = q[LAST];
endmodule

// File: rtl/replay_phase.sv
module replay_phase
    import replay_pkg::*;
#(
    parameter int unsigned LEN = 392
) (
    input  logic         clk,
    input  logic         rst,
    input  replay_mode_e mode,
    output logic         wrap
);
    localparam int unsigned PW = phase_width(LEN);
    localparam logic [PW-1:0] LAST_PH = PW'(LEN - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (mode != MODE_LOOP) begin
            phase_q <= '0;
        end else if (phase_q == LAST_PH) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign wrap = (mode == MODE_LOOP) && (phase_q == '0);
endmodule

// File: rtl/bitstream_replayer.sv
module bitstream_replayer
    import replay_pkg::*;
#(
    parameter int unsigned PAT_LEN = 392
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic loop_sel,
    output logic bit_out,
    output logic wrap_strobe
);
    replay_mode_e mode;
    logic         tail;
    logic         wrap_i;
    replay_out_t  outs;

    assign mode = replay_mode_e'(loop_sel);

    replay_chain #(.LEN(PAT_LEN)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .ser_in (ser_in),
        .tail   (tail)
    );

    replay_phase #(.LEN(PAT_LEN)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .wrap (wrap_i)
    );

    always_comb begin
        outs.bit_val = (mode == MODE_LOOP) ? tail : 1'b0;
        outs.wrap    = wrap_i;
    end

    assign bit_out     = outs.bit_val;
    assign wrap_strobe = outs.wrap;
endmodule

// File: rtl/replay_checker.sv
module replay_checker #(
    parameter int unsigned LEN = 392
) (
    input logic clk,
    input logic rst,
    input logic loop_sel,
    input logic bit_out,
    input logic wrap_strobe
);
    logic in_run_q;
    logic done_q;
    int   gap_q;
    int   ones_q;
    int   prev_ones_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_run_q    <= 1'b0;
            done_q      <= 1'b0;
            gap_q       <= 0;
            ones_q      <= 0;
            prev_ones_q <= 0;
        end else begin
            in_run_q <= loop_sel;
            if (!loop_sel) begin
                gap_q  <= 1;
                ones_q <= 0;
                done_q <= 1'b0;
            end else if (wrap_strobe) begin
                gap_q  <= 1;
                ones_q <= bit_out ? 1 : 0;
                if (in_run_q) begin
                    prev_ones_q <= ones_q;
                    done_q      <= 1'b1;
                end
            end else begin
                gap_q  <= gap_q + 1;
                ones_q <= ones_q + (bit_out ? 1 : 0);
            end
        end
    end

    // R1: stream starts cleared right after reset
    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bit_out);

    // R2: nothing leaves the block in load mode
    assert_load_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !loop_sel |-> (!bit_out && !wrap_strobe));

    // R5: first loop cycle carries the marker
    assert_entry_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (loop_sel && !in_run_q) |-> wrap_strobe);

    // R4: markers spaced by exactly LEN cycles in a run
    assert_wrap_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (loop_sel && in_run_q) |-> (wrap_strobe == (gap_q == LEN)));

    // R7: each full period carries the same number of ones
    assert_density_R7: assert property (@(posedge clk) disable iff (rst)
        (loop_sel && in_run_q && wrap_strobe && done_q) |-> (ones_q == prev_ones_q));
endmodule

bind bitstream_replayer replay_checker #(.LEN(PAT_LEN)) u_replay_chk (
    .clk         (clk),
    .rst         (rst),
    .loop_sel    (loop_sel),
    .bit_out     (bit_out),
    .wrap_strobe (wrap_strobe)
);

// File: tb/test_bitstream_replayer.sv
module test_bitstream_replayer;
    localparam int N = 20;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic loop_sel = 1'b0;
    logic bit_out;
    logic wrap_strobe;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitstream_replayer #(.PAT_LEN(N)) i_bitstream_replayer (
        .clk         (clk),
        .rst         (rst),
        .ser_in      (ser_in),
        .loop_sel    (loop_sel),
        .bit_out     (bit_out),
        .wrap_strobe (wrap_strobe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // load cnt bits, bits[0] first; R2 output quiet during load
    task automatic load_bits(input logic [63:0] bits, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            loop_sel = 1'b0;
            ser_in   = bits[i];
            #1;
            check("R2", "bit_out in load", int'(bit_out), 0);
            check("R2", "wrap in load", int'(wrap_strobe), 0);
        end
    endtask

    // replay and compare with expected pattern exp[0] first
    task automatic replay(input string req, input logic [N-1:0] exp, input int cycles);
        int ones = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            loop_sel = 1'b1;
            #1;
            check(req, "R3/R4 bit_out", int'(bit_out), int'(exp[k % N]));
            check(req, "R5 wrap", int'(wrap_strobe), int'((k % N) == 0));
            ones += int'(bit_out);
            if ((k % N) == N - 1) begin
                check(req, "R7 ones per period", ones, $countones(exp));
                ones = 0;
            end
        end
    endtask

    task automatic leave_loop();
        @(negedge clk);
        loop_sel = 1'b0;
        #1;
        check("R2", "bit_out after leaving loop", int'(bit_out), 0);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        loop_sel = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "bit_out in reset", int'(bit_out), 0);
        check("R1", "wrap in reset", int'(wrap_strobe), 0);
        @(negedge clk);
        rst = 1'b0;
        replay("R1", '0, 2 * N);
        leave_loop();
    endtask

    task automatic t_irregular();
        logic [N-1:0] p = 20'hB5A4D;
        load_bits(64'(p), N);
        replay("R3", p, 3 * N);
        leave_loop();
    endtask

    task automatic t_dc_patterns();
        logic [N-1:0] ones_p = '1;
        logic [N-1:0] alt_p  = 20'h55555;
        load_bits(64'(ones_p), N);
        replay("R7", ones_p, 2 * N);
        leave_loop();
        load_bits(64'(alt_p), N);
        replay("R4", alt_p, 2 * N);
        leave_loop();
    endtask

    task automatic t_overload();
        logic [63:0] raw = 64'h1ABCDEF;
        logic [N-1:0] kept;
        for (int i = 0; i < N; i++) kept[i] = raw[i + 5];
        load_bits(raw, N + 5);
        replay("R6", kept, 2 * N);
        leave_loop();
    endtask

    task automatic t_reentry();
        logic [N-1:0] a = 20'h0F0F3;
        logic [N-1:0] b = 20'hC3A91;
        load_bits(64'(a), N);
        replay("R8", a, 7);
        leave_loop();
        load_bits(64'(b), N);
        replay("R8", b, 2 * N);
        leave_loop();
    endtask

    initial begin
        t_reset_state();
        t_irregular();
        t_dc_patterns();
        t_overload();
        t_reentry();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule